// File: doc/BRIEF.md
# Phase-Comparison Angle-of-Arrival Estimator

This block turns one detected radar cell into an arrival angle. For that cell it takes a single complex sample from each of four receive channels. The channels sit in a straight line, half a wavelength apart. It multiplies each channel by the conjugate of the channel before it and adds up the three products. It then finds the phase of that sum with an iterative CORDIC vectoring unit. The phase, as a fraction of pi, equals the sine of the arrival angle. A binary search over a quarter-wave sine table, built inside the block, turns it into an angle index on a half-degree grid.

One detection is offered at a time on a valid/ready handshake. It carries four signed 16-bit I/Q pairs and a cell tag. The block drops ready while it works. When done, it pulses a result valid with the signed angle index, the unchanged tag and a flag that marks a result with no usable phase. The latency is fixed and well inside a budget of 200 clock cycles.

Top module: `aoa_phase_est`

## Requirements
- R1: After reset, in_ready is high. It goes low in the cycle after a sample set is accepted (in_valid and in_ready high at a rising edge). It stays low until the cycle in which out_valid is high, where it is high again.
- R2: out_tag equals the in_tag of the accepted detection.
- R3: out_angle is a 9-bit two's-complement index in half-degree steps: 0 is broadside, +k is +k/2 degrees, ±180 is ±90 degrees. Channel k of a wave from a positive angle theta carries phase -k·pi·sin(theta), so its phase falls with k.
- R4: For a noiseless plane wave at a grid angle of magnitude up to 179 steps, out_angle is within one step of the true index.
- R5: With up to ±2 LSB of noise on every I and Q sample, an angle of magnitude up to 120 steps is still reported within one step.
- R6: A wave at ±90 degrees, where the phase step between channels is pi, is reported with magnitude 179 or 180.
- R7: If the summed conjugate product is exactly zero, out_angle is 0 and out_invalid is 1. Otherwise out_invalid is 0.
- R8: The number of rising edges from acceptance to the edge that raises out_valid is the same for every detection, and is at most 200.
- R9: While a detection is in progress, in_valid and sample inputs are ignored. Exactly one single-cycle out_valid pulse follows each accepted detection. It carries the accepted tag and angle.
- R10: During and right after reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample set offered |
| in_ready | output | 1 | Block can accept a sample set |
| in_re | input | 64 | Real parts, channel k in bits [16k+15:16k], signed |
| in_im | input | 64 | Imaginary parts, same packing, signed |
| in_tag | input | 8 | Cell tag of the offered detection |
| out_valid | output | 1 | One-cycle result strobe |
| out_angle | output | 9 | Signed angle index, half-degree steps |
| out_tag | output | 8 | Tag of the detection the result belongs to |
| out_invalid | output | 1 | Summed product had zero magnitude |

## Verification
A result is due 28 rising edges after the edge that accepts its samples: 18 vectoring iterations after the loading edge, eight search steps after a start edge, and one output register. in_ready returns high in that same cycle. The bench drives inputs and samples outputs at falling edges. It counts the edges between acceptance and the first falling edge that shows out_valid, then checks that this count is the same every time and no more than 200. Angle, tag and flag are checked only in that cycle. For the ignored-input case, a quiet window after the pulse is watched for any further strobe.

// File: rtl/aoa_pkg.sv
package aoa_pkg;

    localparam int SMP_W    = 16;
    localparam int NCH      = 4;
    localparam int TAG_W    = 8;
    localparam int GRID_MAX = 180;
    localparam int IDX_W    = $clog2(GRID_MAX + 1);
    localparam int ANG_W    = IDX_W + 1;
    localparam int BIT_W    = $clog2(IDX_W);
    localparam int PROD_W   = 2 * SMP_W + 1;
    localparam int SUM_W    = PROD_W + $clog2(NCH);
    localparam int CRD_W    = SUM_W + 2;
    localparam int PH_FRAC  = 17;
    localparam int PH_W     = PH_FRAC + 2;
    localparam int MAG_W    = PH_W - 1;
    localparam int ITERS    = 18;
    localparam int IT_W     = $clog2(ITERS);
    localparam int MAX_CYC  = 200;
    localparam longint STEP_Q30 = 64'd9370166;

    typedef enum logic {ST_IDLE, ST_BUSY} ctl_state_e;

    typedef struct packed {
        logic signed [SUM_W-1:0] re;
        logic signed [SUM_W-1:0] im;
    } csum_t;

    typedef struct packed {
        logic signed [CRD_W-1:0] x;
        logic signed [CRD_W-1:0] y;
        logic signed [PH_W-1:0]  z;
    } vec_t;

    // sine of k half-degree steps, unsigned Q15 (32768 = 1.0), by series
    function automatic logic [16:0] sin_q15(int k);
        longint x, term, acc;
        x = longint'(k) * STEP_Q30;
        acc = x;
        term = x;
        for (int n = 1; n <= 6; n++) begin
            term = (term * x) >>> 30;
            term = (term * x) >>> 30;
            term = -term / longint'((2 * n) * (2 * n + 1));
            acc = acc + term;
        end
        return 17'((acc + 64'd16384) >>> 15);
    endfunction

    // atan(2^-i) in units of pi / 2^17
    function automatic logic signed [PH_W-1:0] atan_step(int i);
        case (i)
            0:  return PH_W'(32768);
            1:  return PH_W'(19344);
            2:  return PH_W'(10221);
            3:  return PH_W'(5188);
            4:  return PH_W'(2604);
            5:  return PH_W'(1303);
            6:  return PH_W'(652);
            7:  return PH_W'(326);
            8:  return PH_W'(163);
            9:  return PH_W'(81);
            10: return PH_W'(41);
            11: return PH_W'(20);
            12: return PH_W'(10);
            13: return PH_W'(5);
            14: return PH_W'(3);
            15: return PH_W'(1);
            16: return PH_W'(1);
            default: return PH_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/aoa_pair_sum.sv
module aoa_pair_sum
    import aoa_pkg::*;
(
    input  logic [NCH*SMP_W-1:0] re_flat,
    input  logic [NCH*SMP_W-1:0] im_flat,
    output csum_t                sum
);

    logic signed [PROD_W-1:0] xr [NCH];
    logic signed [PROD_W-1:0] xi [NCH];
    logic signed [PROD_W-1:0] pr [NCH-1];
    logic signed [PROD_W-1:0] pq [NCH-1];

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_unpack
            assign xr[g] = PROD_W'($signed(re_flat[g*SMP_W +: SMP_W]));
            assign xi[g] = PROD_W'($signed(im_flat[g*SMP_W +: SMP_W]));
        end
        // x[g+1] * conj(x[g])
        for (genvar g = 0; g < NCH - 1; g++) begin : g_pair
            assign pr[g] = xr[g+1] * xr[g] + xi[g+1] * xi[g];
            assign pq[g] = xi[g+1] * xr[g] - xr[g+1] * xi[g];
        end
    endgenerate

    always_comb begin
        sum.re = '0;
        sum.im = '0;
        for (int k = 0; k < NCH - 1; k++) begin
            sum.re = sum.re + SUM_W'(pr[k]);
            sum.im = sum.im + SUM_W'(pq[k]);
        end
    end

endmodule

// File: rtl/aoa_cordic_vec.sv
module aoa_cordic_vec
    import aoa_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  csum_t                  vin,
    output logic                   done,
    output logic signed [PH_W-1:0] phase
);

    localparam logic signed [PH_W-1:0] PH_PI = PH_W'(2 ** PH_FRAC);

    vec_t                    v_q, v_nx;
    logic                    busy_q;
    logic [IT_W-1:0]         it_q;
    logic signed [CRD_W-1:0] xe, ye, xs, ys;

    always_comb begin
        xe = CRD_W'(vin.re);
        ye = CRD_W'(vin.im);
        xs = v_q.x >>> it_q;
        ys = v_q.y >>> it_q;
        v_nx = v_q;
        if (v_q.y >= 0) begin
            v_nx.x = v_q.x + ys;
            v_nx.y = v_q.y - xs;
            v_nx.z = v_q.z + atan_step(int'(it_q));
        end else begin
            v_nx.x = v_q.x - ys;
            v_nx.y = v_q.y + xs;
            v_nx.z = v_q.z - atan_step(int'(it_q));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q    <= '0;
            busy_q <= 1'b0;
            it_q   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                it_q   <= '0;
                if (xe < 0) begin
                    v_q.x <= -xe;
                    v_q.y <= -ye;
                    v_q.z <= (ye >= 0) ? PH_PI : -PH_PI;
                end else begin
                    v_q.x <= xe;
                    v_q.y <= ye;
                    v_q.z <= '0;
                end
            end else if (busy_q) begin
                v_q <= v_nx;
                if (it_q == IT_W'(ITERS - 1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    it_q <= it_q + 1'b1;
                end
            end
        end
    end

    assign phase = v_q.z;

    // vectoring keeps the vector in the right half plane
    assert_x_nonneg_R4: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (v_q.x >= 0));

endmodule

// File: rtl/aoa_asin_search.sv
module aoa_asin_search
    import aoa_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic signed [PH_W-1:0]  phase,
    output logic                    done,
    output logic signed [ANG_W-1:0] angle
);

    localparam int TAB_N = 2 ** IDX_W;

    logic [MAG_W-1:0] tab [TAB_N];
    logic [MAG_W-1:0] mag_q;
    logic             neg_q;
    logic             busy_q;
    logic [IDX_W-1:0] k_q, cand;
    logic [BIT_W-1:0] bit_q;

    generate
        for (genvar g = 0; g < TAB_N; g++) begin : g_tab
            localparam logic [MAG_W-1:0] TV =
                (g <= GRID_MAX) ? (MAG_W'(sin_q15(g)) << 2) : {MAG_W{1'b1}};
            assign tab[g] = TV;
        end
    endgenerate

    assign cand  = k_q | (IDX_W'(1) << bit_q);
    assign angle = neg_q ? -$signed({1'b0, k_q}) : $signed({1'b0, k_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_q  <= '0;
            neg_q  <= 1'b0;
            busy_q <= 1'b0;
            k_q    <= '0;
            bit_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                mag_q  <= MAG_W'((phase < 0) ? -phase : phase);
                neg_q  <= (phase > 0);
                k_q    <= '0;
                bit_q  <= BIT_W'(IDX_W - 1);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (tab[cand] <= mag_q) k_q <= cand;
                if (bit_q == '0) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    bit_q <= bit_q - 1'b1;
                end
            end
        end
    end

    assert_grid_bound_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (k_q <= IDX_W'(GRID_MAX)));

endmodule

// File: rtl/aoa_phase_est.sv
module aoa_phase_est
    import aoa_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [NCH*SMP_W-1:0]    in_re,
    input  logic [NCH*SMP_W-1:0]    in_im,
    input  logic [TAG_W-1:0]        in_tag,
    output logic                    out_valid,
    output logic signed [ANG_W-1:0] out_angle,
    output logic [TAG_W-1:0]        out_tag,
    output logic                    out_invalid
);

    localparam int LAT_W = $clog2(MAX_CYC) + 2;

    ctl_state_e              st_q;
    csum_t                   sum;
    logic                    accept, zero_in, zero_q, crd_done, srch_done;
    logic [TAG_W-1:0]        tag_q;
    logic signed [PH_W-1:0]  phase;
    logic signed [ANG_W-1:0] srch_angle;
    logic [LAT_W-1:0]        lat_q;

    assign in_ready = (st_q == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign zero_in  = (sum.re == '0) && (sum.im == '0);

    aoa_pair_sum i_sum (
        .re_flat (in_re),
        .im_flat (in_im),
        .sum     (sum)
    );

    aoa_cordic_vec i_cordic (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .vin   (sum),
        .done  (crd_done),
        .phase (phase)
    );

    aoa_asin_search i_search (
        .clk   (clk),
        .rst   (rst),
        .start (crd_done),
        .phase (phase),
        .done  (srch_done),
        .angle (srch_angle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            tag_q       <= '0;
            zero_q      <= 1'b0;
            out_valid   <= 1'b0;
            out_angle   <= '0;
            out_tag     <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (accept) begin
                st_q   <= ST_BUSY;
                tag_q  <= in_tag;
                zero_q <= zero_in;
            end
            if (srch_done) begin
                st_q        <= ST_IDLE;
                out_valid   <= 1'b1;
                out_angle   <= zero_q ? '0 : srch_angle;
                out_tag     <= tag_q;
                out_invalid <= zero_q;
            end
        end
    end

    // edge count since acceptance, used only by the budget check
    always_ff @(posedge clk) begin
        if (rst)                                   lat_q <= '0;
        else if (accept)                           lat_q <= LAT_W'(1);
        else if (st_q == ST_BUSY && !(&lat_q))     lat_q <= lat_q + 1'b1;
    end

    assert_ready_drop_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_invalid_zero_R7: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> (out_angle == '0));

    assert_budget_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (lat_q <= LAT_W'(MAX_CYC)));

    assert_angle_range_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_angle <= ANG_W'(GRID_MAX) && out_angle >= -ANG_W'(GRID_MAX)));

endmodule

// File: tb/test_aoa_phase_est.sv
`timescale 1ns/1ps
module test_aoa_phase_est;

    localparam real PI_R = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_re = '0;
    logic [63:0] in_im = '0;
    logic [7:0]  in_tag = '0;
    logic        out_valid;
    logic signed [8:0] out_angle;
    logic [7:0]  out_tag;
    logic        out_invalid;

    int n_chk = 0;
    int n_bad = 0;
    int ref_lat = -1;

    always #2 clk = ~clk;

    aoa_phase_est i_aoa_phase_est (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_re (in_re), .in_im (in_im), .in_tag (in_tag),
        .out_valid (out_valid), .out_angle (out_angle),
        .out_tag (out_tag), .out_invalid (out_invalid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    // plane wave: channel k phase = ph0 - k*pi*sin(theta)
    task automatic load_wave(input int idx, input int amp, input real ph0, input int nz);
        real s, ph;
        int  vr, vi;
        s = $sin(real'(idx) * 0.5 * PI_R / 180.0);
        for (int k = 0; k < 4; k++) begin
            ph = ph0 - real'(k) * PI_R * s;
            vr = rnd(real'(amp) * $cos(ph));
            vi = rnd(real'(amp) * $sin(ph));
            if (nz > 0) begin
                vr = vr + int'($urandom_range(2 * nz)) - nz;
                vi = vi + int'($urandom_range(2 * nz)) - nz;
            end
            in_re[k*16 +: 16] = 16'(vr);
            in_im[k*16 +: 16] = 16'(vi);
        end
    endtask

    task automatic run_one(input int idx, input logic [7:0] tag, input bit zero,
                           input int amp, input int nz, input bit poke);
        int  lat;
        bit  seen;
        int  got;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready while idle", int'(in_ready), 1);
        if (zero) begin
            in_re = '0;
            in_im = '0;
        end else begin
            load_wave(idx, amp, real'($urandom_range(6283)) / 1000.0, nz);
        end
        in_tag = tag;
        in_valid = 1'b1;
        @(posedge clk);
        lat = 0;
        seen = 1'b0;
        for (int c = 0; c < 400 && !seen; c++) begin
            @(negedge clk);
            if (c == 0) begin
                in_valid = 1'b0;
                chk(in_ready == 1'b0, "R1 ready low after accept", int'(in_ready), 0);
            end
            if (poke && c == 3) begin
                load_wave(-idx, amp, 0.3, 0);
                in_tag = ~tag;
                in_valid = 1'b1;
            end
            if (poke && c == 6) in_valid = 1'b0;
            if (out_valid) seen = 1'b1;
            else begin
                @(posedge clk);
                lat++;
            end
        end
        chk(seen, "R9 result strobe", int'(seen), 1);
        if (!seen) return;
        if (ref_lat < 0) ref_lat = lat;
        chk(lat == ref_lat && lat <= 200, "R8 latency", lat, ref_lat);
        chk(in_ready == 1'b1, "R1 ready back with result", int'(in_ready), 1);
        chk(out_tag == tag, "R2 tag", int'(out_tag), int'(tag));
        got = int'(out_angle);
        if (zero) begin
            chk(got == 0, "R7 zero product angle", got, 0);
            chk(out_invalid == 1'b1, "R7 invalid flag set", int'(out_invalid), 1);
        end else begin
            chk(out_invalid == 1'b0, "R7 invalid flag clear", int'(out_invalid), 0);
            if (idx == 180 || idx == -180)
                chk(got >= 179 || got <= -179, "R6 endfire magnitude", got, idx);
            else if (nz > 0)
                chk(got - idx <= 1 && idx - got <= 1, "R5 noisy angle", got, idx);
            else
                chk(got - idx <= 1 && idx - got <= 1, "R4 R3 angle", got, idx);
        end
        if (poke) begin
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (out_valid) chk(1'b0, "R9 extra strobe", 1, 0);
            end
            chk(1'b1, "R9 no extra strobe", 0, 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

        // directed grid points, including near and at endfire (R3 R4 R6)
        run_one(0,    8'h01, 1'b0, 20000, 0, 1'b0);
        run_one(1,    8'h02, 1'b0, 20000, 0, 1'b0);
        run_one(-1,   8'h03, 1'b0, 20000, 0, 1'b0);
        run_one(60,   8'h04, 1'b0, 12000, 0, 1'b0);
        run_one(-60,  8'h05, 1'b0, 12000, 0, 1'b0);
        run_one(90,   8'h06, 1'b0, 30000, 0, 1'b0);
        run_one(179,  8'h07, 1'b0, 30000, 0, 1'b0);
        run_one(-179, 8'h08, 1'b0, 30000, 0, 1'b0);
        run_one(180,  8'h09, 1'b0, 25000, 0, 1'b0);
        run_one(-180, 8'h0A, 1'b0, 25000, 0, 1'b0);
        run_one(100,  8'h0B, 1'b0, 400,   0, 1'b0);

        // zero magnitude (R7)
        run_one(0, 8'h5A, 1'b1, 0, 0, 1'b0);

        // busy inputs ignored (R9)
        run_one(40, 8'hC3, 1'b0, 20000, 0, 1'b1);

        // random noiseless (R4)
        for (int n = 0; n < 30; n++)
            run_one(int'($urandom_range(358)) - 179, 8'(n + 16), 1'b0,
                    6000 + int'($urandom_range(24000)), 0, 1'b0);

        // random noisy (R5)
        for (int n = 0; n < 20; n++)
            run_one(int'($urandom_range(240)) - 120, 8'(n + 64), 1'b0, 20000, 2, 1'b0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule